// File: doc/BRIEF.md
# Watchpoint Control Register Access Window

This block is the external debug view onto a bank of up to sixteen watchpoint control words. A debugger issues single-cycle requests on a simple memory-mapped bus (byte address, write data, write strobe, read strobe). Requests that land on a control word get one response one cycle later. The response carries a valid flag, an error flag and the read data.

Five status inputs decide the rights of every access on the cycle it is presented. These inputs are core power, double lock, OS lock, external-debug permission and software lock. An access can be refused with an error, treated as read-only, or treated as read-write. Slots above the implemented count read as zero and discard writes, unless the lock state refuses the access outright. Reserved bits never hold a one.

The request side has no back-pressure: a request is taken on every cycle it is presented. The response side has no ready signal, so the requester must take the response on the cycle it is flagged. Control and status pins are plain levels.

Top module: `wpt_ctrl_window`

## Requirements
- R1: Control word n (0..15) sits at byte offset 0x808 + 16*n. A request to any other offset produces no response (`rsp_valid` stays low) and changes no state.
- R2: An access is permitted only when `core_pwr`=1, `dbl_lock`=0, `os_lock`=0 and `ext_allow`=1. Otherwise the response has `rsp_err`=1 and `rsp_rdata`=0, and a write changes nothing.
- R3: When access is permitted and `sw_lock`=1, a write completes with `rsp_err`=0 and leaves the word unchanged.
- R4: When access is permitted and `sw_lock`=0, a write stores the data and a later read returns it.
- R5: For an index at or above `NUM_WP`, a permitted access has `rsp_err`=0, reads 0 and ignores writes.
- R6: For an index at or above `NUM_WP`, an access that the lock state refuses returns `rsp_err`=1.
- R7: Bits 31:29 and 23:21 of every word always read as 0, whatever was written.
- R8: The response (`rsp_valid`, `rsp_err`, `rsp_rdata`) appears exactly one cycle after the request. `rsp_valid` is high for one cycle per request, and write responses carry `rsp_rdata`=0.
- R9: After reset every control word reads 0.
- R10: A request with both `wr_en` and `rd_en` high is handled as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 32 | Write data |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| core_pwr | input | 1 | Core is powered |
| dbl_lock | input | 1 | Double lock engaged |
| os_lock | input | 1 | OS lock engaged |
| ext_allow | input | 1 | External debug access permitted |
| sw_lock | input | 1 | Software lock engaged (read-only) |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 32 | Read data |

## Verification
All three response outputs are registered once, so each is due on the first rising edge after the request edge. A write is visible to a read issued on the very next cycle. The bench drives each request on a falling edge and samples the response on the following falling edge. By then exactly one rising edge has passed, and the expected value is computed before the bench's model is updated. Requests are issued back to back, so the one-cycle, one-pulse timing rule is also held by a clocked property that checks every cycle.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned MAX_WP   = 16;
  localparam int unsigned IDX_W    = $clog2(MAX_WP);
  localparam logic [11:0] WIN_BASE = 12'h808;
  // bits that can hold a one: 28:24 and 20:0
  localparam logic [WORD_W-1:0] KEEP_MASK = 32'h1F1F_FFFF;

  typedef struct packed {
    logic       hit;
    logic [IDX_W-1:0] idx;
  } dec_t;
endpackage

// File: rtl/wpt_addr_dec.sv
module wpt_addr_dec #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output wpt_pkg::dec_t     dec
);
  import wpt_pkg::*;
  localparam int unsigned LO_W = 4;
  localparam int unsigned HI_L = LO_W + IDX_W;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(WIN_BASE);

  always_comb begin
    dec.hit = (addr[LO_W-1:0] == BASE[LO_W-1:0]) &&
              (addr[ADDR_W-1:HI_L] == BASE[ADDR_W-1:HI_L]);
    dec.idx = addr[HI_L-1:LO_W];
  end
endmodule

// File: rtl/wpt_access_gate.sv
module wpt_access_gate (
  input  logic core_pwr,
  input  logic dbl_lock,
  input  logic os_lock,
  input  logic ext_allow,
  input  logic sw_lock,
  output logic permit,
  output logic may_write
);
  always_comb begin
    permit    = core_pwr && !dbl_lock && !os_lock && ext_allow;
    may_write = permit && !sw_lock;
  end
endmodule

// File: rtl/wpt_reg_bank.sv
module wpt_reg_bank #(
  parameter int unsigned NUM_WP = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [wpt_pkg::IDX_W-1:0]     idx,
  input  logic [wpt_pkg::WORD_W-1:0]    wdata,
  output logic [wpt_pkg::WORD_W-1:0]    rdata
);
  import wpt_pkg::*;
  logic [WORD_W-1:0] slot [MAX_WP];

  for (genvar g = 0; g < MAX_WP; g++) begin : g_slot
    if (g < NUM_WP) begin : g_impl
      always_ff @(posedge clk) begin
        if (!rst_n)
          slot[g] <= '0;
        else if (we && idx == IDX_W'(g))
          slot[g] <= wdata & KEEP_MASK;
      end
    end else begin : g_absent
      assign slot[g] = '0;
    end
  end

  assign rdata = slot[idx];
endmodule

// File: rtl/wpt_ctrl_window.sv
module wpt_ctrl_window #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NUM_WP = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              core_pwr,
  input  logic              dbl_lock,
  input  logic              os_lock,
  input  logic              ext_allow,
  input  logic              sw_lock,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata
);
  import wpt_pkg::*;

  dec_t              dec;
  logic              permit, may_write;
  logic              req, bank_we;
  logic [WORD_W-1:0] bank_rdata, rdata_n;

  wpt_addr_dec #(.ADDR_W(ADDR_W)) u_dec (.addr(req_addr), .dec(dec));

  wpt_access_gate u_gate (
    .core_pwr(core_pwr), .dbl_lock(dbl_lock), .os_lock(os_lock),
    .ext_allow(ext_allow), .sw_lock(sw_lock),
    .permit(permit), .may_write(may_write)
  );

  always_comb begin
    req     = dec.hit && (wr_en || rd_en);
    bank_we = dec.hit && wr_en && may_write;
    rdata_n = (req && !wr_en && permit) ? bank_rdata : '0;
  end

  wpt_reg_bank #(.NUM_WP(NUM_WP)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .idx(dec.idx),
    .wdata(req_wdata), .rdata(bank_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req;
      rsp_err   <= req && !permit;
      rsp_rdata <= rdata_n;
    end
  end
endmodule

// File: rtl/wpt_ctrl_window_chk.sv
module wpt_ctrl_window_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic        core_pwr,
  input logic        dbl_lock,
  input logic        os_lock,
  input logic        ext_allow,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [31:0] rsp_rdata
);
  // R8
  rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en || rd_en) |=> !rsp_valid);
  // R2
  err_matches_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) && !(core_pwr && !dbl_lock && !os_lock && ext_allow)
      |=> !rsp_valid || rsp_err);
  // R2
  err_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid && rsp_rdata == 32'h0);
  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_rdata[31:29] == 3'b000 && rsp_rdata[23:21] == 3'b000);
  // R8
  write_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rsp_rdata == 32'h0);
  // R2
  permit_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_pwr && !dbl_lock && !os_lock && ext_allow) |=> !rsp_err);
endmodule

bind wpt_ctrl_window wpt_ctrl_window_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .core_pwr(core_pwr), .dbl_lock(dbl_lock), .os_lock(os_lock),
  .ext_allow(ext_allow), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .rsp_rdata(rsp_rdata)
);

// File: tb/sim_wpt_ctrl_window.sv
module sim_wpt_ctrl_window;
  localparam int NWP = 12;
  localparam logic [31:0] KEEP = 32'h1F1F_FFFF;
  // status packing {pwr, dbl, os, ext, sw}
  localparam logic [4:0] ST_RW = 5'b10010;
  localparam logic [4:0] ST_RO = 5'b10011;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic wr_en = 0, rd_en = 0;
  logic core_pwr = 0, dbl_lock = 0, os_lock = 0, ext_allow = 0, sw_lock = 0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [31:0] model [16];
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  wpt_ctrl_window #(.ADDR_W(12), .NUM_WP(NWP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_wdata(req_wdata),
    .wr_en(wr_en), .rd_en(rd_en), .core_pwr(core_pwr), .dbl_lock(dbl_lock),
    .os_lock(os_lock), .ext_allow(ext_allow), .sw_lock(sw_lock),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata));

  function automatic logic [11:0] slot_addr(input int n);
    return 12'h808 + 12'(16 * n);
  endfunction

  function automatic logic permitted(input logic [4:0] st);
    return st[4] && !st[3] && !st[2] && st[1];
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic xact(input logic [11:0] a, input logic w, r,
                      input logic [31:0] d, input logic [4:0] st, input string tag);
    logic hit, impl, ok, ev, ee;
    logic [31:0] ed;
    int idx;
    hit  = (a[3:0] == 4'h8) && (a[11:8] == 4'h8);
    idx  = int'(a[7:4]);
    impl = idx < NWP;
    ok   = permitted(st);
    ev   = hit && (w || r);
    ee   = ev && !ok;
    ed   = (ev && ok && !w && impl) ? model[idx] : 32'h0;
    if (hit && w && ok && !st[0] && impl) model[idx] = d & KEEP;
    req_addr = a; req_wdata = d; wr_en = w; rd_en = r;
    {core_pwr, dbl_lock, os_lock, ext_allow, sw_lock} = st;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    chk(rsp_valid == ev, {tag, " valid"}, 32'(rsp_valid), 32'(ev));
    if (ev) begin
      chk(rsp_err == ee, {tag, " err"}, 32'(rsp_err), 32'(ee));
      chk(rsp_rdata == ed, {tag, " data"}, rsp_rdata, ed);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed_0042);
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(rsp_valid == 1'b0, "R9 reset valid", 32'(rsp_valid), 0);
    // R9: all slots zero after reset
    for (int i = 0; i < 16; i++) xact(slot_addr(i), 0, 1, 0, ST_RW, "R9 reset read");
    // R4: write then read
    xact(slot_addr(3), 1, 0, 32'h0000_1235, ST_RW, "R4 write");
    xact(slot_addr(3), 0, 1, 0, ST_RW, "R4 readback");
    // R7: reserved bits stripped
    xact(slot_addr(0), 1, 0, 32'hFFFF_FFFF, ST_RW, "R7 write ones");
    xact(slot_addr(0), 0, 1, 0, ST_RW, "R7 read 1F1FFFFF");
    // R3: software lock makes writes vanish
    xact(slot_addr(3), 1, 0, 32'h0000_00FF, ST_RO, "R3 ro write");
    xact(slot_addr(3), 0, 1, 0, ST_RO, "R3 ro read");
    // R2: each refusing condition
    xact(slot_addr(3), 1, 0, 32'h1, 5'b00010, "R2 no power");
    xact(slot_addr(3), 0, 1, 0, 5'b11010, "R2 double lock");
    xact(slot_addr(3), 1, 0, 32'h2, 5'b10110, "R2 os lock");
    xact(slot_addr(3), 0, 1, 0, 5'b10000, "R2 no ext");
    xact(slot_addr(3), 0, 1, 0, ST_RW, "R2 unchanged");
    // R5, R6: unimplemented slots
    xact(slot_addr(13), 1, 0, 32'h0000_0FF1, ST_RW, "R5 absent write");
    xact(slot_addr(13), 0, 1, 0, ST_RW, "R5 absent read");
    xact(slot_addr(15), 0, 1, 0, 5'b10110, "R6 absent locked");
    // R1: off-window offsets
    xact(12'h800, 1, 0, 32'h7, ST_RW, "R1 off 800");
    xact(12'h80C, 0, 1, 0, ST_RW, "R1 off 80C");
    xact(12'h908, 1, 0, 32'h7, ST_RW, "R1 off 908");
    xact(slot_addr(11), 0, 1, 0, ST_RW, "R1 last impl");
    // R10: both strobes act as write
    xact(slot_addr(5), 1, 1, 32'h0000_0AB1, ST_RW, "R10 both");
    xact(slot_addr(5), 0, 1, 0, ST_RW, "R10 readback");
    // R8: back-to-back then idle
    xact(slot_addr(5), 0, 1, 0, ST_RW, "R8 b2b");
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8 single pulse", 32'(rsp_valid), 0);
    // random mix
    for (int k = 0; k < 1500; k++) begin
      logic [11:0] a;
      logic [4:0] st;
      logic w, r;
      a  = ($urandom % 10 < 8) ? slot_addr(int'($urandom % 16)) : 12'($urandom);
      st = ($urandom % 10 < 7) ? {4'b1001, 1'($urandom)} : 5'($urandom);
      w  = 1'($urandom);
      r  = 1'($urandom);
      xact(a, w, r, $urandom, st, "R4 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule